// File: doc/BRIEF.md
# Flag Hoist Sequence Controller

This block runs a flag up and down a pole. It has four one-hot step bits and moves through them in a fixed ring: lowering, waiting at the bottom, raising, waiting at the top, and then lowering again. Two momentary push buttons ask for a raise or a lower. Two limit switches report when the flag reaches the top or the bottom of the pole. The block drives one motor command for each direction. It also exposes its step vector so that the step can be observed.

When reset is asserted the controller always starts in the lowering step. The flag therefore runs down to the bottom switch before any button is accepted. Every external input passes through a flop chain before the step logic uses it, so asynchronous switch contacts can be wired in directly. A transition clears the current step bit and sets the next one in the same clock. An input that the current step does not wait on leaves the step unchanged.

Top module: `flag_hoist_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, `step_q` becomes 4'b0001 (lowering) after that edge, `motor_dn` is 1 and `motor_up` is 0.
- R2: In the lowering step (`step_q` = 4'b0001) `motor_dn` is 1. A high `bot_lim` moves the step to 4'b0010 (idle at bottom).
- R3: In the idle-at-bottom step (4'b0010) both motors are 0. A high `raise_btn` moves the step to 4'b0100 (raising), including when `lower_btn` is high at the same time.
- R4: In the raising step (4'b0100) `motor_up` is 1. A high `top_lim` moves the step to 4'b1000 (idle at top).
- R5: In the idle-at-top step (4'b1000) both motors are 0. A high `lower_btn` moves the step back to 4'b0001.
- R6: A button held high for a single clock cycle is enough to leave an idle step.
- R7: A button or limit switch that the current step does not wait on leaves `step_q` and the motor outputs unchanged.
- R8: `step_q` always has exactly one bit set, and `motor_up` and `motor_dn` are never 1 together.
- R9: An input that is sampled high at a rising edge changes `step_q` after the third rising edge, counting that one. The two edges before it leave `step_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_btn | input | 1 | Momentary raise request |
| lower_btn | input | 1 | Momentary lower request |
| top_lim | input | 1 | Top-of-pole limit switch |
| bot_lim | input | 1 | Bottom-of-pole limit switch |
| motor_up | output | 1 | Raise motor command |
| motor_dn | output | 1 | Lower motor command |
| step_q | output | 4 | One-hot step: bit0 lowering, bit1 idle bottom, bit2 raising, bit3 idle top |

## Verification
An input pulse crosses two synchroniser flops and then the step register. The new step and the motor commands that decode from it are therefore due after the third rising edge following the edge that first samples the pulse. The bench drives each stimulus for one cycle at a falling edge and samples the outputs three falling edges later. For the latency case it also samples after two edges and expects the old step there. Reset needs no synchroniser, so its result is checked one falling edge after the reset is driven.

// File: rtl/flag_hoist_ctrl.sv
module flag_hoist_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       raise_btn,
  input  logic       lower_btn,
  input  logic       top_lim,
  input  logic       bot_lim,
  output logic       motor_up,
  output logic       motor_dn,
  output logic [3:0] step_q
);
  localparam int LOWERING = 0;
  localparam int RAISING  = 2;
  localparam logic [3:0] ST_LOWER  = 4'b0001;
  localparam logic [3:0] ST_BOTTOM = 4'b0010;
  localparam logic [3:0] ST_RAISE  = 4'b0100;
  localparam logic [3:0] ST_TOP    = 4'b1000;

  logic [3:0] sync_s [SYNC_STAGES];
  logic [3:0] step_nxt;
  logic       s_raise, s_lower, s_top, s_bot;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_s[i] <= '0;
    end else begin
      sync_s[0] <= {raise_btn, lower_btn, top_lim, bot_lim};
      for (int i = 1; i < SYNC_STAGES; i++) sync_s[i] <= sync_s[i-1];
    end
  end

  assign {s_raise, s_lower, s_top, s_bot} = sync_s[SYNC_STAGES-1];

  always_comb begin
    step_nxt = step_q;
    case (step_q)
      ST_LOWER:  if (s_bot)   step_nxt = ST_BOTTOM;
      ST_BOTTOM: if (s_raise) step_nxt = ST_RAISE;
      ST_RAISE:  if (s_top)   step_nxt = ST_TOP;
      ST_TOP:    if (s_lower) step_nxt = ST_LOWER;
      default:                step_nxt = ST_LOWER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_LOWER;
    else     step_q <= step_nxt;
  end

  assign motor_up = step_q[RAISING];
  assign motor_dn = step_q[LOWERING];
endmodule

module flag_hoist_chk (
  input logic       clk,
  input logic       rst,
  input logic       motor_up,
  input logic       motor_dn,
  input logic [3:0] step_q
);
  // R1
  reset_start_chk: assert property (@(posedge clk) rst |=> (step_q == 4'b0001 && motor_dn && !motor_up));
  // R8
  one_hot_chk: assert property (@(posedge clk) disable iff (rst) $countones(step_q) == 1);
  // R8
  motor_excl_chk: assert property (@(posedge clk) disable iff (rst) !(motor_up && motor_dn));
  // R2
  lower_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q == 4'b0001) |=> (step_q == 4'b0001 || step_q == 4'b0010));
  // R3
  bottom_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q == 4'b0010) |=> (step_q == 4'b0010 || step_q == 4'b0100));
  // R4
  raise_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q == 4'b0100) |=> (step_q == 4'b0100 || step_q == 4'b1000));
  // R5
  top_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q == 4'b1000) |=> (step_q == 4'b1000 || step_q == 4'b0001));
endmodule

bind flag_hoist_ctrl flag_hoist_chk chk_i (
  .clk(clk), .rst(rst), .motor_up(motor_up), .motor_dn(motor_dn), .step_q(step_q)
);

// File: tb/flag_hoist_ctrl_tb.sv
`timescale 1ns/1ps
module flag_hoist_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raise_btn = 1'b0, lower_btn = 1'b0, top_lim = 1'b0, bot_lim = 1'b0;
  logic motor_up, motor_dn;
  logic [3:0] step_q;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  flag_hoist_ctrl dut_i (
    .clk(clk), .rst(rst), .raise_btn(raise_btn), .lower_btn(lower_btn),
    .top_lim(top_lim), .bot_lim(bot_lim),
    .motor_up(motor_up), .motor_dn(motor_dn), .step_q(step_q)
  );

  // {raise, lower, top, bot, expected step}
  localparam logic [7:0] VEC [12] = '{
    8'b0001_0010, 8'b0100_0010, 8'b0010_0010, 8'b1000_0100,
    8'b1000_0100, 8'b0001_0100, 8'b0010_1000, 8'b1000_1000,
    8'b0100_0001, 8'b0010_0001, 8'b1000_0001, 8'b0001_0010
  };

  function automatic string tag_of(logic [3:0] prev, logic [3:0] exp);
    if (prev == exp)        return "R7";
    if (exp == 4'b0010)     return "R2";
    if (exp == 4'b0100)     return "R3 R6";
    if (exp == 4'b1000)     return "R4";
    return "R5 R6";
  endfunction

  task automatic check(string tag, logic [3:0] exp);
    n_run++;
    if (step_q !== exp || motor_up !== (exp == 4'b0100) || motor_dn !== (exp == 4'b0001)) begin
      n_fail++;
      $display("FAIL %s: step=%b up=%b dn=%b expected step=%b up=%b dn=%b", tag,
               step_q, motor_up, motor_dn, exp, exp == 4'b0100, exp == 4'b0001);
    end
    n_run++;
    if (motor_up && motor_dn) begin
      n_fail++;
      $display("FAIL R8: up=%b dn=%b expected not both", motor_up, motor_dn);
    end
  endtask

  task automatic pulse(logic [3:0] v);
    @(negedge clk);
    {raise_btn, lower_btn, top_lim, bot_lim} = v;
    @(negedge clk);
    {raise_btn, lower_btn, top_lim, bot_lim} = 4'b0000;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [3:0] prev;
    repeat (3) @(negedge clk);
    check("R1 reset", 4'b0001);
    rst = 1'b0;
    prev = 4'b0001;
    for (int i = 0; i < 12; i++) begin
      pulse(VEC[i][7:4]);
      check(tag_of(prev, VEC[i][3:0]), VEC[i][3:0]);
      prev = VEC[i][3:0];
    end

    // R9: latency of three edges
    @(negedge clk);
    raise_btn = 1'b1;
    @(negedge clk);
    raise_btn = 1'b0;
    check("R9 edge1", 4'b0010);
    @(negedge clk);
    check("R9 edge2", 4'b0010);
    @(negedge clk);
    check("R9 edge3", 4'b0100);

    // R1: reset in the middle of raising
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", 4'b0001);
    rst = 1'b0;

    // R7: every input except the bottom switch is ignored while lowering
    pulse(4'b1110);
    check("R7 lowering ignores", 4'b0001);
    pulse(4'b0001);
    check("R2 bottom reached", 4'b0010);
    // R3: both buttons together, raise wins
    pulse(4'b1100);
    check("R3 both buttons", 4'b0100);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule